// File: doc/BRIEF.md
# Step/Direction Microstep Sequencer

This block stands in for a host processor in a two-phase microstepping drive. A step pulse and a direction level move an up/down position counter. The counter indexes a table that holds one electrical cycle of sine and cosine phase currents. For every update the block issues bus writes to a two-channel register interface. Each write carries a chip select, a channel address bit, an 8-bit sign/magnitude byte and a write strobe. Each write loads one channel only, so the block orders the writes and keeps the bus timing between them.

A mode input picks between two ways of updating the windings. In paired mode, each step produces a channel 1 write and then, after the shortest allowed pause, a channel 2 write. In alternating mode, each step produces a single write, and the channel changes from one step to the next. Two neighbouring table entries then combine into an intermediate microstep position.

Steps that arrive while the bus is busy go into a small queue, which keeps the direction of each step. They are served in arrival order. After reset, the block writes the first table entry to both channels and only then begins to serve steps.

Top module: `ustep_seq`

## Requirements
- R1: While reset is high and after it is released, `bus_cs_n` and `bus_wr_n` are 1. After release, the position is 0 and the table entry for position 0 is written first to channel 1 and then to channel 2, before any step is served.
- R2: A written byte holds the sign in bit 7 (1 = reversed phase current) and the magnitude 0..127 in bits 6..0. Let N = 2^POS_W. For index k, let q = k mod N/2 and m = min(q, N/2-q). Winding 1 then has sign (k >= N/2) and magnitude round(127·sin(π/2·m/(N/4))). Winding 2 uses the same rule at index (k+N/4) mod N.
- R3: `bus_chan` = 0 addresses channel 1 and carries the winding 1 byte. `bus_chan` = 1 addresses channel 2 and carries the winding 2 byte.
- R4: A rising edge on `step_i` moves the position by +1 when `dir_i` = 1 and by -1 when `dir_i` = 0. The position wraps modulo N in both directions.
- R5: With `mode_i` = 0, each step causes exactly two writes: channel 1, then channel 2. `bus_cs_n` of the second write falls exactly GAP_CYC+2 cycles after the strobe of the first write rises.
- R6: With `mode_i` = 1, each step causes exactly one write. The channel alternates from one such write to the next and starts with channel 1 after reset. Paired-mode updates do not change whose turn is next.
- R7: In every write, `bus_wr_n` falls exactly SETUP_CYC cycles after `bus_cs_n` falls and stays low exactly STROBE_CYC cycles. `bus_wr_n` rises together with `bus_cs_n`, and it is never low while `bus_cs_n` is high. `bus_data` and `bus_chan` stay constant while `bus_cs_n` is low.
- R8: Up to 2^PEND_W steps that arrive while an update is in progress are held. Each is served in arrival order with its own direction. None is lost, and no write is made that does not belong to a step or to the reset update.
- R9: `mode_i` is sampled when a step begins service, so changing the mode between steps changes the kind of update that the next step gets.
- R10: Steps that arrive during the reset update are queued. They are served after both reset writes complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step request; each rising edge is one step |
| dir_i | input | 1 | Direction sampled with the step edge (1 = up) |
| mode_i | input | 1 | 0 = paired writes per step, 1 = one alternating write per step |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_chan | output | 1 | Channel address bit (0 = channel 1) |
| bus_data | output | 8 | Sign/magnitude data byte |
| bus_wr_n | output | 1 | Write strobe; data is taken on its rising edge |

## Verification
Spaced single steps are swept upward and downward through more than one full electrical cycle in both modes. This separates the table contents, the wrap in each direction and the channel order of each mode. Short bursts of steps with mixed directions, sent faster than the bus can serve them, show whether the queue keeps both order and direction. Steps sent during the reset update show that the reset writes come first. Every write is also timed against the setup, strobe and pairing gap counts, which separates a misordered or stretched bus cycle from a correct one.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

  typedef enum logic [2:0] {
    SQ_LOOK,
    SQ_IDLE,
    SQ_ISSUE1,
    SQ_WAIT1,
    SQ_ISSUE2,
    SQ_WAIT2
  } seq_state_t;

  typedef enum logic [1:0] {
    WP_IDLE,
    WP_SETUP,
    WP_STROBE,
    WP_GAP
  } wphase_t;

  localparam real QUARTER_TURN = 1.5707963267948966;

  // Sign/magnitude phase byte for index idx of a cycle of len samples
  function automatic logic [7:0] phase_byte(input int idx, input int len);
    int  half_len;
    int  quarter_len;
    int  q;
    int  m;
    int  mag;
    real s;
    half_len    = len / 2;
    quarter_len = len / 4;
    q   = idx % half_len;
    m   = (q <= quarter_len) ? q : (half_len - q);
    s   = $sin(QUARTER_TURN * real'(m) / real'(quarter_len));
    mag = $rtoi(127.0 * s + 0.5);
    return {(idx >= half_len), 7'(mag)};
  endfunction

endpackage

// File: rtl/ustep_queue.sv
module ustep_queue #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic dir_i,
  input  logic pop,
  output logic avail,
  output logic dir_o
);
  localparam int DEPTH = 1 << PEND_W;
  localparam logic [PEND_W:0] FULL = (PEND_W + 1)'(DEPTH);

  logic              step_q;
  logic [DEPTH-1:0]  dir_mem;
  logic [PEND_W-1:0] wp;
  logic [PEND_W-1:0] rp;
  logic [PEND_W:0]   cnt;
  logic              rise;
  logic              push;
  logic              take;

  assign rise  = step_i & ~step_q;
  assign take  = pop && (cnt != '0);
  assign push  = rise && ((cnt != FULL) || take);
  assign avail = (cnt != '0);
  assign dir_o = dir_mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
    end else begin
      step_q <= step_i;
      if (push) begin
        dir_mem[wp] <= dir_i;
        wp          <= wp + 1'b1;
      end
      if (take) rp <= rp + 1'b1;
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ustep_rom.sv
module ustep_rom #(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic [POS_W-1:0] addr,
  output logic [7:0]       q_a,
  output logic [7:0]       q_b
);
  import ustep_pkg::*;

  localparam int LEN     = 1 << POS_W;
  localparam int QUARTER = LEN / 4;

  logic [7:0] tbl_a [LEN];
  logic [7:0] tbl_b [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_tbl
    assign tbl_a[i] = phase_byte(i, LEN);
    assign tbl_b[i] = phase_byte((i + QUARTER) % LEN, LEN);
  end

  always_ff @(posedge clk) begin
    q_a <= tbl_a[addr];
    q_b <= tbl_b[addr];
  end
endmodule

// File: rtl/ustep_bus_wr.sv
module ustep_bus_wr #(
  parameter int SETUP_CYC  = 9,
  parameter int STROBE_CYC = 7,
  parameter int GAP_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ch_in,
  input  logic [7:0] byte_in,
  output logic       cs_n,
  output logic       chan,
  output logic [7:0] data,
  output logic       wr_n,
  output logic       done
);
  import ustep_pkg::*;

  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAXC   = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  wphase_t       ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= WP_IDLE;
      cnt  <= '0;
      cs_n <= 1'b1;
      wr_n <= 1'b1;
      chan <= 1'b0;
      data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        WP_IDLE: begin
          if (start) begin
            cs_n <= 1'b0;
            chan <= ch_in;
            data <= byte_in;
            cnt  <= CW'(SETUP_CYC - 1);
            ph   <= WP_SETUP;
          end
        end
        WP_SETUP: begin
          if (cnt == '0) begin
            wr_n <= 1'b0;
            cnt  <= CW'(STROBE_CYC - 1);
            ph   <= WP_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WP_STROBE: begin
          if (cnt == '0) begin
            wr_n <= 1'b1;
            cs_n <= 1'b1;
            cnt  <= CW'(GAP_CYC - 1);
            ph   <= WP_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            done <= 1'b1;
            ph   <= WP_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ustep_seq.sv
module ustep_seq #(
  parameter int POS_W      = 5,
  parameter int PEND_W     = 2,
  parameter int SETUP_CYC  = 9,
  parameter int STROBE_CYC = 7,
  parameter int GAP_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic       mode_i,
  output logic       bus_cs_n,
  output logic       bus_chan,
  output logic [7:0] bus_data,
  output logic       bus_wr_n
);
  import ustep_pkg::*;

  seq_state_t       st;
  logic [POS_W-1:0] pos;
  logic             dual;
  logic             cur_ch;
  logic             turn;

  logic             q_avail;
  logic             q_dir;
  logic             pop;
  logic [7:0]       rom_a;
  logic [7:0]       rom_b;
  logic             wr_start;
  logic             wr_ch;
  logic [7:0]       wr_byte;
  logic             wr_done;

  assign pop      = (st == SQ_IDLE) && q_avail;
  assign wr_start = (st == SQ_ISSUE1) || (st == SQ_ISSUE2);
  assign wr_ch    = (st == SQ_ISSUE2) ? 1'b1 : cur_ch;
  assign wr_byte  = wr_ch ? rom_b : rom_a;

  ustep_queue #(.PEND_W(PEND_W)) i_queue (
    .clk    (clk),
    .rst    (rst),
    .step_i (step_i),
    .dir_i  (dir_i),
    .pop    (pop),
    .avail  (q_avail),
    .dir_o  (q_dir)
  );

  ustep_rom #(.POS_W(POS_W)) i_rom (
    .clk  (clk),
    .addr (pos),
    .q_a  (rom_a),
    .q_b  (rom_b)
  );

  ustep_bus_wr #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) i_bus (
    .clk     (clk),
    .rst     (rst),
    .start   (wr_start),
    .ch_in   (wr_ch),
    .byte_in (wr_byte),
    .cs_n    (bus_cs_n),
    .chan    (bus_chan),
    .data    (bus_data),
    .wr_n    (bus_wr_n),
    .done    (wr_done)
  );

  // Reset enters the lookup state directly, so position 0 is written to both channels
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_LOOK;
      pos    <= '0;
      dual   <= 1'b1;
      cur_ch <= 1'b0;
      turn   <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (q_avail) begin
            pos    <= q_dir ? (pos + 1'b1) : (pos - 1'b1);
            dual   <= ~mode_i;
            cur_ch <= mode_i ? turn : 1'b0;
            if (mode_i) turn <= ~turn;
            st     <= SQ_LOOK;
          end
        end
        SQ_LOOK:   st <= SQ_ISSUE1;
        SQ_ISSUE1: st <= SQ_WAIT1;
        SQ_WAIT1: begin
          if (wr_done) st <= dual ? SQ_ISSUE2 : SQ_IDLE;
        end
        SQ_ISSUE2: st <= SQ_WAIT2;
        SQ_WAIT2: begin
          if (wr_done) st <= SQ_IDLE;
        end
        default:   st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ustep_seq_chk.sv
module ustep_seq_chk #(
  parameter int SETUP_CYC  = 9,
  parameter int STROBE_CYC = 7
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_cs_n,
  input logic       bus_chan,
  input logic [7:0] bus_data,
  input logic       bus_wr_n
);
  int cs_lo;
  int wr_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_lo <= 0;
      wr_lo <= 0;
    end else begin
      cs_lo <= bus_cs_n ? 0 : cs_lo + 1;
      wr_lo <= bus_wr_n ? 0 : wr_lo + 1;
    end
  end

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> !bus_cs_n);

  // R7
  setup_time_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> (cs_lo >= SETUP_CYC));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> (wr_lo == STROBE_CYC));

  // R7
  release_together_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> bus_cs_n);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_data) && $stable(bus_chan)));
endmodule

bind ustep_seq ustep_seq_chk #(
  .SETUP_CYC  (SETUP_CYC),
  .STROBE_CYC (STROBE_CYC)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_cs_n (bus_cs_n),
  .bus_chan (bus_chan),
  .bus_data (bus_data),
  .bus_wr_n (bus_wr_n)
);

// File: tb/test_ustep_seq.sv
module test_ustep_seq;
  localparam int POS_W  = 4;
  localparam int N      = 1 << POS_W;
  localparam int PEND_W = 2;
  localparam int SETUP  = 9;
  localparam int STROBE = 7;
  localparam int GAP    = 2;
  localparam int XMAX   = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_i = 1'b0;
  logic       dir_i = 1'b0;
  logic       mode_i = 1'b0;
  logic       bus_cs_n;
  logic       bus_chan;
  logic [7:0] bus_data;
  logic       bus_wr_n;

  always #4 clk = ~clk;

  ustep_seq #(
    .POS_W(POS_W), .PEND_W(PEND_W), .SETUP_CYC(SETUP),
    .STROBE_CYC(STROBE), .GAP_CYC(GAP)
  ) i_ustep_seq (
    .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i), .mode_i(mode_i),
    .bus_cs_n(bus_cs_n), .bus_chan(bus_chan), .bus_data(bus_data), .bus_wr_n(bus_wr_n)
  );

  int checks = 0;
  int errors = 0;
  int exp_n = 0;
  int got_n = 0;
  logic [7:0] exp_data [XMAX];
  logic       exp_chan [XMAX];
  logic       exp_pair2 [XMAX];
  string      exp_tag [XMAX];
  int m_pos = 0;
  int m_turn = 0;

  function automatic int mag_of(input int k);
    int q;
    int m;
    q = k % (N / 2);
    m = (q <= N / 4) ? q : (N / 2 - q);
    return $rtoi(127.0 * $sin(1.5707963267948966 * real'(m) / real'(N / 4)) + 0.5);
  endfunction

  function automatic logic [7:0] byte_w1(input int k);
    return {(k >= N / 2), 7'(mag_of(k))};
  endfunction

  function automatic logic [7:0] byte_w2(input int k);
    return byte_w1((k + N / 4) % N);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic ch, input logic [7:0] d, input logic p2,
                          input string tag);
    exp_chan[exp_n]  = ch;
    exp_data[exp_n]  = d;
    exp_pair2[exp_n] = p2;
    exp_tag[exp_n]   = tag;
    exp_n++;
  endtask

  task automatic model_reset(input string tag);
    m_pos  = 0;
    m_turn = 0;
    push_exp(1'b0, byte_w1(0), 1'b0, tag);
    push_exp(1'b1, byte_w2(0), 1'b1, tag);
  endtask

  task automatic model_step(input logic d, input logic md, input string tag);
    m_pos = d ? (m_pos + 1) % N : (m_pos + N - 1) % N;
    if (!md) begin
      push_exp(1'b0, byte_w1(m_pos), 1'b0, tag);
      push_exp(1'b1, byte_w2(m_pos), 1'b1, tag);
    end else begin
      push_exp(m_turn[0], m_turn[0] ? byte_w2(m_pos) : byte_w1(m_pos), 1'b0, tag);
      m_turn ^= 1;
    end
  endtask

  // Bus monitor, sampled between edges
  int   cyc = 0;
  int   cs_fall = 0;
  int   wr_fall = 0;
  int   wr_rise = 0;
  logic prev_cs = 1'b1;
  logic prev_wr = 1'b1;
  logic [7:0] d0;
  logic c0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_cs = 1'b1;
      prev_wr = 1'b1;
    end else begin
      if (prev_cs && !bus_cs_n) begin
        cs_fall = cyc;
        d0 = bus_data;
        c0 = bus_chan;
        if (got_n < exp_n && exp_pair2[got_n])
          chk(cyc - wr_rise == GAP + 2, "R5", "pair gap", cyc - wr_rise, GAP + 2);
      end
      if (!bus_wr_n && bus_cs_n)
        chk(1'b0, "R7", "strobe without select", 1, 0);
      if (prev_wr && !bus_wr_n)
        chk(cyc - cs_fall == SETUP, "R7", "setup cycles", cyc - cs_fall, SETUP);
      if (!prev_wr && bus_wr_n) begin
        chk(cyc - wr_fall == STROBE, "R7", "strobe cycles", cyc - wr_fall, STROBE);
        chk(bus_cs_n == 1'b1, "R7", "select release", int'(bus_cs_n), 1);
        chk(bus_data == d0 && bus_chan == c0, "R7", "data hold",
            {bus_chan, bus_data}, {c0, d0});
        if (got_n >= exp_n) begin
          chk(1'b0, "R8", "unexpected write", {bus_chan, bus_data}, 0);
        end else begin
          chk(bus_chan == exp_chan[got_n] && bus_data == exp_data[got_n],
              exp_tag[got_n], "write content", {bus_chan, bus_data},
              {exp_chan[got_n], exp_data[got_n]});
          got_n++;
        end
        wr_rise = cyc;
      end
      if (prev_wr && !bus_wr_n) wr_fall = cyc;
      prev_cs = bus_cs_n;
      prev_wr = bus_wr_n;
    end
  end

  task automatic pulse(input logic d);
    @(negedge clk);
    dir_i  = d;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w;
    w = 0;
    while (got_n < exp_n && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk(got_n == exp_n, tag, "writes seen", got_n, exp_n);
    repeat (40) @(negedge clk);
  endtask

  task automatic spaced_step(input logic d, input string tag);
    pulse(d);
    model_step(d, mode_i, tag);
    drain(tag);
  endtask

  task automatic burst_step(input logic d, input string tag);
    pulse(d);
    model_step(d, mode_i, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_cs_n == 1'b1 && bus_wr_n == 1'b1, tag, "idle bus in reset",
        {bus_cs_n, bus_wr_n}, 2'b11);
    model_reset(tag);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 R2 R3: reset update writes entry 0 to channel 1 then channel 2
    do_reset("R1 R2 R3 init");
    @(negedge clk);
    chk(bus_cs_n == 1'b1 && bus_wr_n == 1'b1, "R1", "idle after release",
        {bus_cs_n, bus_wr_n}, 2'b11);
    drain("R1 init");

    // R4 R5: paired mode sweeps in both directions across the wrap
    mode_i = 1'b0;
    for (int i = 0; i < N + 3; i++) spaced_step(1'b1, "R2 R4 R5 up");
    for (int i = 0; i < 2 * N + 2; i++) spaced_step(1'b0, "R2 R4 R5 down");

    // R6: alternating mode sweeps
    mode_i = 1'b1;
    for (int i = 0; i < N + 2; i++) spaced_step(1'b1, "R4 R6 single up");
    for (int i = 0; i < N / 2 + 1; i++) spaced_step(1'b0, "R4 R6 single down");

    // R9 R6: mode changes between steps; turn survives paired updates
    for (int i = 0; i < 6; i++) begin
      mode_i = i[0];
      spaced_step(i[1], "R6 R9 mixed");
    end

    // R8: bursts faster than service, mixed directions
    mode_i = 1'b0;
    burst_step(1'b1, "R8 burst paired");
    burst_step(1'b0, "R8 burst paired");
    burst_step(1'b0, "R8 burst paired");
    burst_step(1'b1, "R8 burst paired");
    burst_step(1'b1, "R8 burst paired");
    drain("R8 burst paired");
    mode_i = 1'b1;
    burst_step(1'b0, "R8 burst single");
    burst_step(1'b0, "R8 burst single");
    burst_step(1'b1, "R8 burst single");
    burst_step(1'b0, "R8 burst single");
    burst_step(1'b0, "R8 burst single");
    drain("R8 burst single");

    // R10: steps during the reset update wait for it
    do_reset("R1 R10 reinit");
    burst_step(1'b1, "R10 queued");
    burst_step(1'b1, "R10 queued");
    burst_step(1'b0, "R10 queued");
    drain("R10 queued");

    chk(got_n == exp_n, "R8", "total writes", got_n, exp_n);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule